// File: doc/BRIEF.md
# Constrained Power-of-Two Clock Divider Bank

This block holds one 16-bit clock-control word and turns it into six clock-enable pulse trains. All six run from a single root clock. Each domain has a 2-bit exponent `e`, and that domain's enable is high for one root cycle out of every `2^e` cycles. The six domains are peripheral, LCD, CPU, DSP, traffic controller and DSP-MMU.

Software may write any word. The block does not store the word as written. It first repairs the exponent fields so that the required speed relations between domains hold:

- The DSP-MMU domain runs at the DSP rate or at half of it.
- The traffic controller is never faster than the CPU or the DSP-MMU domain.
- The LCD and peripheral domains are never faster than the traffic controller.

Only these relative orderings are enforced; absolute frequency limits are not checked. The repaired word is what the block stores, drives the dividers with, and returns on the read port.

A divisor change is applied to a domain only when that domain's counter ends its current period. This means a write never produces a shortened enable period.

Top module: `ckdiv_bank`

## Requirements
- R1: A domain with exponent `e` asserts its enable for exactly one root cycle in every `2^e` root cycles. With `e = 0` the enable is high every cycle.
- R2: Bits [15:12] of a written word are stored and read back unchanged.
- R3: The stored DSP-MMU exponent is the written one, raised to at least the DSP exponent and then limited to at most the DSP exponent plus one.
- R4: The stored traffic-controller exponent is the written one, raised to at least the CPU exponent and to at least the corrected DSP-MMU exponent.
- R5: The stored LCD and peripheral exponents are each raised to at least the corrected traffic-controller exponent.
- R6: The corrections are applied in the order R3, R4, R5. The read port shows the corrected word from the first cycle after the write. A word that already obeys the rules is stored unchanged. Without a write, the stored word holds.
- R7: The exponent fields sit at these bit positions: peripheral [1:0], LCD [3:2], CPU [5:4], DSP [7:6], traffic controller [9:8], DSP-MMU [11:10]. The enable outputs are indexed in the same domain order: `clk_en[0]` is peripheral and `clk_en[5]` is DSP-MMU.
- R8: A domain switches to a new exponent only when its current period ends. After a write, the next pulse still arrives at the end of the old period.
- R9: After reset, the stored word is 0 and every enable is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to be written (corrected before storage) |
| rd_data | output | 16 | Stored, corrected control word |
| clk_en | output | 6 | One-cycle enable pulse per domain |

## Verification
The stored word changes at the same edge that captures `wr_en`. The bench's monitor registers the strobe on that edge and compares `rd_data` against the queued model value at the following falling edge, exactly one cycle after the write. Enable outputs depend on the counter state and are checked in two ways:
- For rate checks, the bench waits well past the longest period of 8 cycles and then counts pulses over a 32-cycle window.
- For the deferred-switch check, the bench aligns to a pulse and expects the next pulse exactly 8 cycles later and the one after it 9 cycles later.

// File: rtl/ckdiv_pkg.sv
// Package: shared widths, domain indices and exponent type for the divider bank.
// Assumes a 16-bit control word with six 2-bit exponent fields in the low 12 bits.
package ckdiv_pkg;
    localparam int REG_W    = 16;
    localparam int EXP_W    = 2;
    localparam int NUM_DOM  = 6;
    localparam int FIELDS_W = NUM_DOM * EXP_W;

    // Domain indices; field position is index * EXP_W (R7)
    localparam int DOM_PER = 0;
    localparam int DOM_LCD = 1;
    localparam int DOM_CPU = 2;
    localparam int DOM_DSP = 3;
    localparam int DOM_TC  = 4;
    localparam int DOM_MMU = 5;

    typedef logic [EXP_W-1:0] exp_t;
endpackage

// File: rtl/ckdiv_clamp.sv
// Module: combinational repair of a written control word.
// Assumes the field layout from ckdiv_pkg. Upper bits pass through unchanged.
// The steps run in a fixed order, and each step sees the results of the earlier ones.
module ckdiv_clamp
    import ckdiv_pkg::*;
(
    input  logic [REG_W-1:0] raw_word,
    output logic [REG_W-1:0] fixed_word
);
    exp_t per_w, lcd_w, cpu_w, dsp_w, tc_w, mmu_w;
    exp_t per_c, lcd_c, tc_c, mmu_c;

    // Purpose: split the raw word into its exponent fields
    always_comb begin
        per_w = raw_word[DOM_PER*EXP_W +: EXP_W];
        lcd_w = raw_word[DOM_LCD*EXP_W +: EXP_W];
        cpu_w = raw_word[DOM_CPU*EXP_W +: EXP_W];
        dsp_w = raw_word[DOM_DSP*EXP_W +: EXP_W];
        tc_w  = raw_word[DOM_TC*EXP_W  +: EXP_W];
        mmu_w = raw_word[DOM_MMU*EXP_W +: EXP_W];
    end

    // Purpose: clamp the DSP-MMU exponent into [dsp, dsp+1]
    always_comb begin
        mmu_c = mmu_w;
        if (mmu_c < dsp_w)
            mmu_c = dsp_w;
        if ({1'b0, mmu_c} > ({1'b0, dsp_w} + 3'd1))
            mmu_c = dsp_w + exp_t'(1);
    end

    // Purpose: raise the traffic-controller exponent to the CPU and corrected MMU values
    always_comb begin
        tc_c = tc_w;
        if (tc_c < cpu_w)
            tc_c = cpu_w;
        if (tc_c < mmu_c)
            tc_c = mmu_c;
    end

    // Purpose: raise the LCD and peripheral exponents to the corrected traffic-controller value
    always_comb begin
        lcd_c = (lcd_w < tc_c) ? tc_c : lcd_w;
        per_c = (per_w < tc_c) ? tc_c : per_w;
    end

    // Purpose: reassemble the repaired word with the upper bits untouched
    always_comb begin
        fixed_word = raw_word;
        fixed_word[DOM_PER*EXP_W +: EXP_W] = per_c;
        fixed_word[DOM_LCD*EXP_W +: EXP_W] = lcd_c;
        fixed_word[DOM_CPU*EXP_W +: EXP_W] = cpu_w;
        fixed_word[DOM_DSP*EXP_W +: EXP_W] = dsp_w;
        fixed_word[DOM_TC*EXP_W  +: EXP_W] = tc_c;
        fixed_word[DOM_MMU*EXP_W +: EXP_W] = mmu_c;
    end
endmodule

// File: rtl/ckdiv_domain.sv
// Module: one domain's power-of-two enable generator.
// It counts from 0 to 2^exp-1 and pulses while the count is 0.
// A new exponent is sampled only at the wrap, so a period is never cut short.
// Assumes exp_in is stable apart from register writes.
module ckdiv_domain #(
    parameter int EXP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_in,
    output logic             en_out
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [EXP_W-1:0] act_exp;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             wrap;

    // Purpose: last count value of the active period
    always_comb begin
        last_cnt = CNT_W'((CNT_W+1)'(1) << act_exp) - CNT_W'(1);
        wrap     = (cnt == last_cnt);
    end

    // Purpose: advance the counter and load a new exponent at the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            act_exp <= '0;
        end else if (wrap) begin
            cnt     <= '0;
            act_exp <= exp_in;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Purpose: one-cycle enable at the start of every period
    assign en_out = (cnt == '0);

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt); // R1
    AST_EXP_AT_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_exp)); // R8
    AST_PULSE_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_out && act_exp != '0) |=> !en_out); // R1
endmodule

// File: rtl/ckdiv_bank.sv
// Module: top of the divider bank. It holds the corrected control word and fans
// the exponent fields out to one enable generator per domain.
// Assumes a single root clock and a synchronous active-low reset.
module ckdiv_bank
    import ckdiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic [NUM_DOM-1:0]  clk_en
);
    logic [REG_W-1:0] fixed_word;
    logic [REG_W-1:0] ctl_q;

    ckdiv_clamp u_clamp (
        .raw_word   (wr_data),
        .fixed_word (fixed_word)
    );

    // Purpose: store the repaired word on a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= fixed_word;
    end

    assign rd_data = ctl_q;

    // Purpose: one enable generator per domain, fed from its field
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        ckdiv_domain #(.EXP_W(EXP_W)) u_dom (
            .clk    (clk),
            .rst_n  (rst_n),
            .exp_in (ctl_q[d*EXP_W +: EXP_W]),
            .en_out (clk_en[d])
        );
    end

    AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctl_q[REG_W-1:FIELDS_W] == $past(wr_data[REG_W-1:FIELDS_W])); // R2
    AST_MMU_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[DOM_MMU*EXP_W +: EXP_W] >= ctl_q[DOM_DSP*EXP_W +: EXP_W]) &&
        ({1'b0, ctl_q[DOM_MMU*EXP_W +: EXP_W]} <= {1'b0, ctl_q[DOM_DSP*EXP_W +: EXP_W]} + 3'd1)); // R3
    AST_TC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[DOM_TC*EXP_W +: EXP_W] >= ctl_q[DOM_CPU*EXP_W +: EXP_W]) &&
        (ctl_q[DOM_TC*EXP_W +: EXP_W] >= ctl_q[DOM_MMU*EXP_W +: EXP_W])); // R4
    AST_SLOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[DOM_LCD*EXP_W +: EXP_W] >= ctl_q[DOM_TC*EXP_W +: EXP_W]) &&
        (ctl_q[DOM_PER*EXP_W +: EXP_W] >= ctl_q[DOM_TC*EXP_W +: EXP_W])); // R5
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q)); // R6
endmodule

// File: tb/sim_ckdiv_bank.sv
`timescale 1ns/1ps
module sim_ckdiv_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [5:0]  clk_en;

    int checks = 0;
    int errors = 0;
    logic cap = 1'b0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    ckdiv_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .clk_en(clk_en)
    );

    // Reference correction written from R3..R5 in R6 order
    function automatic logic [15:0] model(input logic [15:0] w);
        int per = w[1:0], lcd = w[3:2], cpu = w[5:4];
        int dsp = w[7:6], tc = w[9:8], mmu = w[11:10];
        logic [15:0] r;
        if (mmu < dsp) mmu = dsp;
        if (mmu > dsp + 1) mmu = dsp + 1;
        if (tc < cpu) tc = cpu;
        if (tc < mmu) tc = mmu;
        if (lcd < tc) lcd = tc;
        if (per < tc) per = tc;
        r = {w[15:12], 2'(mmu), 2'(tc), 2'(dsp), 2'(cpu), 2'(lcd), 2'(per)};
        return r;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Driver: one write cycle, expected readback pushed to the scoreboard
    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        exp_q.push_back(model(w));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compare readback one cycle after each captured write
    always @(posedge clk) cap <= wr_en;
    always @(negedge clk) begin
        if (cap) begin
            if (exp_q.size() == 0) begin
                check("R6 queue", 1, 0);
            end else begin
                check("R6 readback", rd_data, exp_q.pop_front());
            end
        end
    end

    // Count each domain's pulses over 32 cycles and compare with 32 >> exponent
    task automatic rates(input string req, input logic [15:0] word);
        int cnt [6];
        for (int d = 0; d < 6; d++) cnt[d] = 0;
        repeat (20) @(negedge clk);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            for (int d = 0; d < 6; d++) cnt[d] += clk_en[d];
        end
        for (int d = 0; d < 6; d++)
            check(req, cnt[d], 32 >> word[d*2 +: 2]);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset word", rd_data, 16'h0000);
        rates("R9 R1 reset rates", 16'h0000);

        // R3 R4 R5 R2: mmu above dsp+1 pulled down, chain raised
        wr(16'h5C00);
        check("R3 R4 R5 R2 case A", rd_data, 16'h5505);
        // R3 R4 R5: mmu raised to dsp, tc to cpu
        wr(16'h00B3);
        check("R3 R4 R5 case B", rd_data, 16'h0BBF);
        rates("R1 R7 rates B", 16'h0BBF);
        // R6: legal word unchanged
        wr(16'hF65B);
        check("R6 legal kept", rd_data, 16'hF65B);
        rates("R1 R7 rates C", 16'hF65B);
        // R2 R6: all-ones stays, upper bits kept
        wr(16'hFFFF);
        check("R2 all ones", rd_data, 16'hFFFF);
        wr(16'h9ACE);
        check("R6 model", rd_data, model(16'h9ACE));
        wr(16'h3C21);
        check("R6 model 2", rd_data, model(16'h3C21));

        // R8: CPU at period 8, then switch to exponent 0 mid-period
        wr(16'h033F);
        repeat (20) @(negedge clk);
        while (!clk_en[2]) @(negedge clk);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (k == 1) begin
                wr_en = 1'b1;
                wr_data = 16'h030F;
                exp_q.push_back(model(16'h030F));
            end
            if (k == 2) wr_en = 1'b0;
            check("R8 deferred switch", clk_en[2], (k >= 8) ? 1 : 0);
        end
        rates("R1 R8 rates after switch", 16'h030F);

        // R6: no write, word holds
        repeat (10) @(negedge clk);
        check("R6 hold", rd_data, 16'h030F);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule